// File: doc/BRIEF.md
# Local-Only Victim Buffer

This block is a small fully associative store for lines that a shared L2 cache has just evicted. When a local processor read misses in the main array, the same address is presented on the lookup port. If the buffer holds the line, the data comes back one cycle later and the entry is released so the line can be reinstalled in the main array. Requests that arrive from the network are flagged as remote. They always get a miss, because buffered data is not kept consistent for other nodes.

Two events discard an entry without returning it: a local write to the address, and an invalidation from the network for the address. Entries are kept in insertion order. When the buffer is full, a new eviction pushes out the oldest line. If a removal has left a free slot, the new line takes that slot and no line is pushed out.

Top module: `victim_buf`

## Requirements
- R1: After reset the buffer is empty, `rsp_valid_o` is low, and any lookup answers a miss.
- R2: A local lookup (`lkp_remote_i` = 0) of a held address sets `rsp_valid_o` and `rsp_hit_o` on the following cycle, with that line's data on `rsp_data_o`. `rsp_valid_o` is high exactly one cycle after each lookup.
- R3: A remote lookup (`lkp_remote_i` = 1) always answers a miss and leaves the entry in place.
- R4: A local lookup hit removes the entry, so an immediate repeat lookup misses.
- R5: A local write to a held address removes that entry. A write to any other address has no effect.
- R6: A network invalidation of a held address removes that entry. An invalidation of any other address has no effect.
- R7: The buffer holds DEPTH (4) lines. An insert into a full buffer drops the line inserted earliest. An insert while a slot is free drops nothing.
- R8: An insert in the same cycle as an invalidation or local write to the same address is not kept.
- R9: Inserting an address already held replaces the old copy. Later hits return the newest data, and the address occupies one slot.
- R10: A miss response drives `rsp_data_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert an evicted line |
| ins_addr_i | input | ADDR_W | Line address of the evicted line |
| ins_data_i | input | DATA_W | Line data of the evicted line |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_remote_i | input | 1 | Lookup comes from the network (always misses) |
| lkp_addr_i | input | ADDR_W | Lookup line address |
| wr_valid_i | input | 1 | Local write notification |
| wr_addr_i | input | ADDR_W | Line address being written |
| inv_valid_i | input | 1 | Network invalidation |
| inv_addr_i | input | ADDR_W | Line address being invalidated |
| rsp_valid_o | output | 1 | Lookup response, one cycle after the lookup |
| rsp_hit_o | output | 1 | Response is a hit |
| rsp_data_o | output | DATA_W | Hit data, zero on a miss |

## Verification
A stale entry left behind by a missed write or invalidation shows up as a false hit on the next local lookup of that address, one cycle after the lookup. A wrong age order does not show when the eviction happens. It shows only later, as a miss on a line that should have survived or a hit on a line that should have been dropped, so the bench fills the buffer past capacity and then probes every address. Random traffic on a pool of eight addresses makes same-cycle collisions between ports frequent, and every response is compared against an ordered reference list.

// File: rtl/vb_pkg.sv
package vb_pkg;
  localparam int unsigned VB_DEPTH  = 4;
  localparam int unsigned VB_ADDR_W = 32;
  localparam int unsigned VB_DATA_W = 64;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int unsigned DEPTH  = vb_pkg::VB_DEPTH,
  parameter int unsigned ADDR_W = vb_pkg::VB_ADDR_W
) (
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] tag_i,
  input  logic                         req_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic [DEPTH-1:0]             hit_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_o[i] = req_i & vld_i[i] & (tag_i[i] == addr_i);
  end
endmodule

// File: rtl/vb_store.sv
// Entries kept packed, index 0 oldest; removals compact, pushes append.
module vb_store #(
  parameter int unsigned DEPTH  = vb_pkg::VB_DEPTH,
  parameter int unsigned ADDR_W = vb_pkg::VB_ADDR_W,
  parameter int unsigned DATA_W = vb_pkg::VB_DATA_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DEPTH-1:0]             keep_i,
  input  logic                         push_i,
  input  logic [ADDR_W-1:0]            push_tag_i,
  input  logic [DATA_W-1:0]            push_data_i,
  output logic [DEPTH-1:0]             vld_o,
  output logic [DEPTH-1:0][ADDR_W-1:0] tag_o,
  output logic [DEPTH-1:0][DATA_W-1:0] data_o
);
  logic [DEPTH-1:0]             vld_q, vld_d;
  logic [DEPTH-1:0][ADDR_W-1:0] tag_q, tag_d;
  logic [DEPTH-1:0][DATA_W-1:0] data_q, data_d;

  always_comb begin
    int cnt;
    cnt    = 0;
    vld_d  = '0;
    tag_d  = '0;
    data_d = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && keep_i[i]) begin
        vld_d[cnt]  = 1'b1;
        tag_d[cnt]  = tag_q[i];
        data_d[cnt] = data_q[i];
        cnt = cnt + 1;
      end
    end
    if (push_i) begin
      if (cnt < int'(DEPTH)) begin
        vld_d[cnt]  = 1'b1;
        tag_d[cnt]  = push_tag_i;
        data_d[cnt] = push_data_i;
      end else begin
        for (int j = 0; j < DEPTH-1; j++) begin
          tag_d[j]  = tag_d[j+1];
          data_d[j] = data_d[j+1];
        end
        tag_d[DEPTH-1]  = push_tag_i;
        data_d[DEPTH-1] = push_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      tag_q  <= tag_d;
      data_q <= data_d;
    end
  end

  assign vld_o  = vld_q;
  assign tag_o  = tag_q;
  assign data_o = data_q;
endmodule

// File: rtl/victim_buf.sv
module victim_buf #(
  parameter int unsigned DEPTH  = vb_pkg::VB_DEPTH,
  parameter int unsigned ADDR_W = vb_pkg::VB_ADDR_W,
  parameter int unsigned DATA_W = vb_pkg::VB_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_valid_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic [DATA_W-1:0] ins_data_i,
  input  logic              lkp_valid_i,
  input  logic              lkp_remote_i,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              inv_valid_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic [DEPTH-1:0]             ent_vld;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_tag;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [DEPTH-1:0]             lkp_hit, wr_hit, inv_hit, dup_hit, keep;
  logic                         lkp_local, ins_kill, push;
  logic [DATA_W-1:0]            rd_data;
  logic                         rsp_valid_q, rsp_hit_q;
  logic [DATA_W-1:0]            rsp_data_q;

  // remote requests never reach the match lane
  assign lkp_local = lkp_valid_i & ~lkp_remote_i;

  vb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_m_lkp (
    .vld_i(ent_vld), .tag_i(ent_tag), .req_i(lkp_local),
    .addr_i(lkp_addr_i), .hit_o(lkp_hit));
  vb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_m_wr (
    .vld_i(ent_vld), .tag_i(ent_tag), .req_i(wr_valid_i),
    .addr_i(wr_addr_i), .hit_o(wr_hit));
  vb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_m_inv (
    .vld_i(ent_vld), .tag_i(ent_tag), .req_i(inv_valid_i),
    .addr_i(inv_addr_i), .hit_o(inv_hit));
  vb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_m_dup (
    .vld_i(ent_vld), .tag_i(ent_tag), .req_i(ins_valid_i),
    .addr_i(ins_addr_i), .hit_o(dup_hit));

  assign keep     = ~(lkp_hit | wr_hit | inv_hit | dup_hit);
  assign ins_kill = (inv_valid_i && inv_addr_i == ins_addr_i) ||
                    (wr_valid_i  && wr_addr_i  == ins_addr_i);
  assign push     = ins_valid_i & ~ins_kill;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lkp_hit[i]) rd_data = rd_data | ent_data[i];
    end
  end

  vb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .keep_i      (keep),
    .push_i      (push),
    .push_tag_i  (ins_addr_i),
    .push_data_i (ins_data_i),
    .vld_o       (ent_vld),
    .tag_o       (ent_tag),
    .data_o      (ent_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= lkp_valid_i;
      rsp_hit_q   <= |lkp_hit;
      rsp_data_q  <= rd_data;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
  parameter int unsigned DEPTH  = vb_pkg::VB_DEPTH,
  parameter int unsigned ADDR_W = vb_pkg::VB_ADDR_W,
  parameter int unsigned DATA_W = vb_pkg::VB_DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ins_valid_i,
  input logic [ADDR_W-1:0] ins_addr_i,
  input logic              lkp_valid_i,
  input logic              lkp_remote_i,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              inv_valid_i,
  input logic [ADDR_W-1:0] inv_addr_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic [DEPTH-1:0]  ent_vld
);
  assert_rsp_follows_lkp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> rsp_valid_o);
  assert_no_rsp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |=> !rsp_valid_o);
  assert_remote_miss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i && lkp_remote_i |=> !rsp_hit_o);
  assert_hit_shrinks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i && !lkp_remote_i && !ins_valid_i ##1 rsp_hit_o
      |-> $countones(ent_vld) < $past($countones(ent_vld)));
  assert_packed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_vld & (ent_vld + 1'b1)) == '0);
  assert_kill_insert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i && ((inv_valid_i && inv_addr_i == ins_addr_i) ||
                    (wr_valid_i && wr_addr_i == ins_addr_i))
      |=> $countones(ent_vld) <= $past($countones(ent_vld)));
  assert_miss_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> rsp_data_o == '0);
  assert_hit_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o);
endmodule

bind victim_buf vb_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ins_valid_i(ins_valid_i), .ins_addr_i(ins_addr_i),
  .lkp_valid_i(lkp_valid_i), .lkp_remote_i(lkp_remote_i), .wr_valid_i(wr_valid_i),
  .wr_addr_i(wr_addr_i), .inv_valid_i(inv_valid_i), .inv_addr_i(inv_addr_i),
  .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_data_o(rsp_data_o),
  .ent_vld(ent_vld));

// File: tb/victim_buf_tb.sv
module victim_buf_tb;
  localparam int D  = 4;
  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ins_valid_i = 1'b0, lkp_valid_i = 1'b0, lkp_remote_i = 1'b0;
  logic          wr_valid_i = 1'b0, inv_valid_i = 1'b0;
  logic [AW-1:0] ins_addr_i = '0, lkp_addr_i = '0, wr_addr_i = '0, inv_addr_i = '0;
  logic [DW-1:0] ins_data_i = '0;
  logic          rsp_valid_o, rsp_hit_o;
  logic [DW-1:0] rsp_data_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [AW-1:0] m_addr [D];
  logic [DW-1:0] m_data [D];
  int            m_cnt = 0;

  always #5 clk_i = ~clk_i;

  victim_buf #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

  function automatic int find(logic [AW-1:0] a);
    for (int i = 0; i < m_cnt; i++) if (m_addr[i] == a) return i;
    return -1;
  endfunction

  task automatic idle();
    ins_valid_i = 0; lkp_valid_i = 0; lkp_remote_i = 0; wr_valid_i = 0; inv_valid_i = 0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one cycle: expectation from reference list, then update list, then compare
  task automatic tick(string tag);
    logic          e_v, e_h;
    logic [DW-1:0] e_d;
    logic [AW-1:0] na [D];
    logic [DW-1:0] nd [D];
    int            nc, k;
    e_v = lkp_valid_i; e_h = 0; e_d = '0;
    if (lkp_valid_i && !lkp_remote_i) begin
      k = find(lkp_addr_i);
      if (k >= 0) begin e_h = 1; e_d = m_data[k]; end
    end
    nc = 0;
    for (int i = 0; i < m_cnt; i++) begin
      if (!((lkp_valid_i && !lkp_remote_i && m_addr[i] == lkp_addr_i) ||
            (wr_valid_i && m_addr[i] == wr_addr_i) ||
            (inv_valid_i && m_addr[i] == inv_addr_i) ||
            (ins_valid_i && m_addr[i] == ins_addr_i))) begin
        na[nc] = m_addr[i]; nd[nc] = m_data[i]; nc++;
      end
    end
    if (ins_valid_i && !(inv_valid_i && inv_addr_i == ins_addr_i)
                    && !(wr_valid_i && wr_addr_i == ins_addr_i)) begin
      if (nc == D) begin
        for (int j = 0; j < D-1; j++) begin na[j] = na[j+1]; nd[j] = nd[j+1]; end
        nc = D - 1;
      end
      na[nc] = ins_addr_i; nd[nc] = ins_data_i; nc++;
    end
    for (int i = 0; i < nc; i++) begin m_addr[i] = na[i]; m_data[i] = nd[i]; end
    m_cnt = nc;
    @(posedge clk_i);
    @(negedge clk_i);
    idle();
    n_chk++;
    if (rsp_valid_o !== e_v || rsp_hit_o !== e_h || rsp_data_o !== e_d) begin
      n_fail++;
      $display("FAIL %s: got v=%0b h=%0b d=%h, expected v=%0b h=%0b d=%h",
               tag, rsp_valid_o, rsp_hit_o, rsp_data_o, e_v, e_h, e_d);
    end
  endtask

  task automatic ins(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    ins_valid_i = 1; ins_addr_i = a; ins_data_i = d; tick(tag);
  endtask
  task automatic look(logic [AW-1:0] a, logic rem, string tag);
    lkp_valid_i = 1; lkp_remote_i = rem; lkp_addr_i = a; tick(tag);
  endtask
  task automatic wr(logic [AW-1:0] a, string tag);
    wr_valid_i = 1; wr_addr_i = a; tick(tag);
  endtask
  task automatic inv(logic [AW-1:0] a, string tag);
    inv_valid_i = 1; inv_addr_i = a; tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (rsp_valid_o !== 1'b0 || rsp_hit_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got v=%0b h=%0b in reset, expected 0 0", rsp_valid_o, rsp_hit_o);
    end
    rst_ni = 1'b1;
    tick("R1");
    look(32'h5, 0, "R1");
    // R2 R3 R4 R10
    ins(32'h10, 64'hA1, "R2");
    look(32'h10, 1, "R3");
    look(32'h10, 0, "R2");
    look(32'h10, 0, "R4");
    look(32'h10, 1, "R10");
    // R5
    ins(32'h20, 64'hB2, "R5");
    wr(32'h21, "R5");
    look(32'h20, 0, "R5");
    ins(32'h20, 64'hB3, "R5");
    wr(32'h20, "R5");
    look(32'h20, 0, "R5");
    // R6
    ins(32'h30, 64'hC3, "R6");
    inv(32'h31, "R6");
    look(32'h30, 0, "R6");
    ins(32'h30, 64'hC4, "R6");
    inv(32'h30, "R6");
    look(32'h30, 0, "R6");
    // R7 overflow
    for (int i = 1; i <= 5; i++) ins(AW'(i), DW'(i * 17), "R7");
    look(32'h1, 0, "R7");
    for (int i = 2; i <= 5; i++) look(AW'(i), 0, "R7");
    // R7 free slot reused
    for (int i = 1; i <= 4; i++) ins(AW'(i + 8), DW'(i), "R7");
    wr(32'hA, "R7");
    ins(32'hD, 64'hDD, "R7");
    look(32'h9, 0, "R7");
    look(32'hD, 0, "R7");
    // R8
    ins_valid_i = 1; ins_addr_i = 32'h40; ins_data_i = 64'h44;
    inv_valid_i = 1; inv_addr_i = 32'h40; tick("R8");
    look(32'h40, 0, "R8");
    ins_valid_i = 1; ins_addr_i = 32'h41; ins_data_i = 64'h45;
    wr_valid_i = 1; wr_addr_i = 32'h41; tick("R8");
    look(32'h41, 0, "R8");
    // R9
    ins(32'h50, 64'h1111, "R9");
    ins(32'h50, 64'h2222, "R9");
    ins(32'h51, 64'h3, "R9");
    ins(32'h52, 64'h4, "R9");
    ins(32'h53, 64'h5, "R9");
    look(32'h50, 0, "R9");
    // random mix, small address pool for collisions
    for (int n = 0; n < 3000; n++) begin
      ins_valid_i  = ($urandom % 3) == 0;
      ins_addr_i   = AW'($urandom % 8);
      ins_data_i   = {$urandom, $urandom};
      lkp_valid_i  = ($urandom % 2) == 0;
      lkp_remote_i = ($urandom % 4) == 0;
      lkp_addr_i   = AW'($urandom % 8);
      wr_valid_i   = ($urandom % 6) == 0;
      wr_addr_i    = AW'($urandom % 8);
      inv_valid_i  = ($urandom % 6) == 0;
      inv_addr_i   = AW'($urandom % 8);
      tick("R2/R3/R4/R5/R6/R7/R8/R9");
    end
    report();
  end
endmodule